// File: doc/BRIEF.md
# Repeated String Transfer and Compare Engine

A sequential engine that carries out one string operation over memory and, when asked, repeats it under control of a 16-bit count. Five operations are supported: copying an element from a source area to a destination area, comparing a source element with a destination element, scanning a destination area for the accumulator value, loading source elements into the accumulator, and filling a destination area with the accumulator. The element size is a byte or a word. A direction input chooses whether the source and destination offsets grow or shrink after each element.

Every memory address is built from a 16-bit segment and a 16-bit offset. The request port moves one byte per handshake, and a word takes two such transfers. After `start` the engine runs on its own until it raises a one-cycle `done`. It then presents the updated offsets, count, accumulator and zero flag. The surrounding datapath captures these values and uses them in place of its own register copies.

Top module: `strx_engine`

## Requirements
- R1: Each byte address equals (segment × 16 + ((offset + byte index) mod 65536)) mod 2^20. The source side uses `ds_in`/`si`, and the destination side uses `es_in`/`di`.
- R2: Op code 0 (copy) reads the source element and then writes it to the destination. A word (`word`=1) moves as two byte transfers, the low byte first at the lower offset.
- R3: Op code 3 (load) reads the source element into `acc_out`. A byte load replaces only bits 7:0. Op code 4 (store) writes `acc_out` to the destination, low byte first.
- R4: Op code 1 (compare) reads the source element and then the destination element, and sets `zf` when they are equal. Op code 2 (scan) reads the destination element, and sets `zf` when it equals the accumulator (bits 7:0 only for bytes). The zf from the last element processed is retained. No other op changes `zf`.
- R5: With `dir`=0 the offsets in use grow after each element, and with `dir`=1 they shrink. The step is 1 for bytes and 2 for words, with 16-bit wraparound. `si` moves only for copy, compare and load. `di` moves only for copy, compare, scan and store.
- R6: With `rep`=0 (no repeat), exactly one element is processed and `cx_out` is left at its start value.
- R7: With `rep`=1 (counted), exactly `cx_in` elements are processed and `cx_out` ends at 0.
- R8: `rep`=2 (while equal) and `rep`=3 (while not equal) decrement the count after each element. For compare and scan, the run stops when the count reaches 0, or when `zf` is 0 (`rep`=2) or 1 (`rep`=3). For the other ops, they behave as counted repeat.
- R9: With any repeat mode and `cx_in`=0, no memory request is issued. `done` rises in the cycle after `start` is accepted, and the offsets, count, accumulator and `zf` keep their values.
- R10: While `mem_req` is high and `mem_rdy` is low, `mem_addr`, `mem_we` and `mem_wdata` hold steady. A transfer completes on a clock edge where both signals are high, and read data is taken on that same edge.
- R11: `start` is accepted only while `busy` is low. `done` is a single-cycle pulse. `mem_req` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 3 | 0 copy, 1 compare, 2 scan, 3 load, 4 store |
| rep | input | 2 | 0 none, 1 counted, 2 while equal, 3 while not equal |
| word | input | 1 | 1 selects word elements, 0 bytes |
| dir | input | 1 | 1 shrinks offsets, 0 grows them |
| si_in | input | 16 | Start source offset |
| di_in | input | 16 | Start destination offset |
| cx_in | input | 16 | Start count |
| ds_in | input | 16 | Source segment |
| es_in | input | 16 | Destination segment |
| acc_in | input | 16 | Start accumulator |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | 1 for a write transfer |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_rdy |
| mem_rdy | input | 1 | Transfer completes on this edge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| zf | output | 1 | Zero flag after the last compare or scan |
| si_out | output | 16 | Current source offset |
| di_out | output | 16 | Current destination offset |
| cx_out | output | 16 | Current count |
| acc_out | output | 16 | Current accumulator |

## Verification
The bench builds the engine with its default parameters: 16-bit offsets, a 4-bit segment shift, a 20-bit address and two-byte words. With these values a segment near 0xFFFF wraps the address past the 20-bit limit, and an offset of 0xFFFF wraps to 0 between the two bytes of one word. Both wraps are driven on purpose. Runs with a stalling memory, and a second `start` raised mid-run, exercise the handshake hold and the rule that a busy engine ignores new starts.

// File: rtl/strx_pkg.sv
package strx_pkg;

    typedef enum logic [2:0] {
        OP_COPY  = 3'd0,
        OP_CMP   = 3'd1,
        OP_SCAN  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_STORE = 3'd4
    } str_op_e;

    typedef enum logic [1:0] {
        RP_NONE  = 2'd0,
        RP_COUNT = 2'd1,
        RP_EQ    = 2'd2,
        RP_NE    = 2'd3
    } rep_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SRC  = 3'd1,
        ST_DST  = 3'd2,
        ST_EVAL = 3'd3,
        ST_DONE = 3'd4
    } eng_state_e;

    function automatic logic op_reads_src(str_op_e o);
        return (o == OP_COPY) || (o == OP_CMP) || (o == OP_LOAD);
    endfunction

    function automatic logic op_uses_dst(str_op_e o);
        return (o != OP_LOAD);
    endfunction

    function automatic logic op_writes_dst(str_op_e o);
        return (o == OP_COPY) || (o == OP_STORE);
    endfunction

    function automatic logic op_sets_flag(str_op_e o);
        return (o == OP_CMP) || (o == OP_SCAN);
    endfunction

endpackage

// File: rtl/strx_addr_gen.sv
module strx_addr_gen #(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = 20,
    parameter int IDX_W     = 1
) (
    input  logic [OFF_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int SUM_W = OFF_W + SEG_SHIFT;

    logic [OFF_W-1:0] off_b;
    logic [SUM_W-1:0] full;

    always_comb begin
        off_b = off + OFF_W'(idx);
        full  = {seg, {SEG_SHIFT{1'b0}}} + SUM_W'(off_b);
        addr  = full[ADDR_W-1:0];
    end
endmodule

// File: rtl/strx_ptr_step.sv
module strx_ptr_step #(
    parameter int OFF_W      = 16,
    parameter int ELEM_BYTES = 2
) (
    input  logic [OFF_W-1:0] ptr,
    input  logic             word,
    input  logic             dir,
    output logic [OFF_W-1:0] ptr_next
);
    logic [OFF_W-1:0] step;

    always_comb begin
        step     = word ? OFF_W'(ELEM_BYTES) : OFF_W'(1);
        ptr_next = dir ? (ptr - step) : (ptr + step);
    end
endmodule

// File: rtl/strx_term_ctl.sv
module strx_term_ctl
    import strx_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  rep_mode_e        rep,
    input  logic             flag_op,
    input  logic             zf_new,
    input  logic [OFF_W-1:0] cx,
    output logic [OFF_W-1:0] cx_dec,
    output logic             keep_going
);
    logic cond_ok;

    always_comb begin
        cx_dec = cx - OFF_W'(1);
        unique case (rep)
            RP_EQ:   cond_ok = !flag_op || zf_new;
            RP_NE:   cond_ok = !flag_op || !zf_new;
            default: cond_ok = 1'b1;
        endcase
        keep_going = (rep != RP_NONE) && (cx_dec != '0) && cond_ok;
    end
endmodule

// File: rtl/strx_engine.sv
module strx_engine
    import strx_pkg::*;
#(
    parameter int OFF_W      = 16,
    parameter int SEG_SHIFT  = 4,
    parameter int ADDR_W     = 20,
    parameter int BYTE_W     = 8,
    parameter int ELEM_BYTES = 2,
    localparam int DATA_W    = BYTE_W * ELEM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [1:0]        rep,
    input  logic              word,
    input  logic              dir,
    input  logic [OFF_W-1:0]  si_in,
    input  logic [OFF_W-1:0]  di_in,
    input  logic [OFF_W-1:0]  cx_in,
    input  logic [OFF_W-1:0]  ds_in,
    input  logic [OFF_W-1:0]  es_in,
    input  logic [DATA_W-1:0] acc_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_rdy,
    output logic              busy,
    output logic              done,
    output logic              zf,
    output logic [OFF_W-1:0]  si_out,
    output logic [OFF_W-1:0]  di_out,
    output logic [OFF_W-1:0]  cx_out,
    output logic [DATA_W-1:0] acc_out
);
    localparam int IDX_W = (ELEM_BYTES > 1) ? $clog2(ELEM_BYTES) : 1;
    localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'({BYTE_W{1'b1}});

    typedef struct packed {
        eng_state_e        st;
        str_op_e           op;
        rep_mode_e         rep;
        logic              word;
        logic              dir;
        logic [OFF_W-1:0]  si;
        logic [OFF_W-1:0]  di;
        logic [OFF_W-1:0]  cx;
        logic [OFF_W-1:0]  ds;
        logic [OFF_W-1:0]  es;
        logic [DATA_W-1:0] acc;
        logic              zf;
        logic [IDX_W-1:0]  bidx;
        logic [DATA_W-1:0] sbuf;
        logic [DATA_W-1:0] dbuf;
    } eng_regs_t;

    eng_regs_t q, d;

    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [OFF_W-1:0]  si_next, di_next, cx_dec;
    logic              keep_going;
    logic              zf_new;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] wsrc, cmp_a, mask;

    // ---------------------------------------------------------------
    // Helper units
    // ---------------------------------------------------------------
    strx_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W), .IDX_W(IDX_W))
        u_src_addr (.seg(q.ds), .off(q.si), .idx(q.bidx), .addr(src_addr));

    strx_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W), .IDX_W(IDX_W))
        u_dst_addr (.seg(q.es), .off(q.di), .idx(q.bidx), .addr(dst_addr));

    strx_ptr_step #(.OFF_W(OFF_W), .ELEM_BYTES(ELEM_BYTES))
        u_si_step (.ptr(q.si), .word(q.word), .dir(q.dir), .ptr_next(si_next));

    strx_ptr_step #(.OFF_W(OFF_W), .ELEM_BYTES(ELEM_BYTES))
        u_di_step (.ptr(q.di), .word(q.word), .dir(q.dir), .ptr_next(di_next));

    strx_term_ctl #(.OFF_W(OFF_W))
        u_term (.rep(q.rep), .flag_op(op_sets_flag(q.op)), .zf_new(zf_new),
                .cx(q.cx), .cx_dec(cx_dec), .keep_going(keep_going));

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        d = q;

        last_idx = q.word ? IDX_W'(ELEM_BYTES - 1) : '0;
        mask     = q.word ? '1 : BYTE_MASK;
        cmp_a    = (q.op == OP_CMP) ? q.sbuf : q.acc;
        zf_new   = op_sets_flag(q.op) ? (((cmp_a ^ q.dbuf) & mask) == '0) : q.zf;
        wsrc     = (q.op == OP_COPY) ? q.sbuf : q.acc;

        mem_req   = (q.st == ST_SRC) || (q.st == ST_DST);
        mem_we    = (q.st == ST_DST) && op_writes_dst(q.op);
        mem_addr  = (q.st == ST_SRC) ? src_addr : dst_addr;
        mem_wdata = wsrc[int'(q.bidx) * BYTE_W +: BYTE_W];

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.op   = str_op_e'(op);
                    d.rep  = rep_mode_e'(rep);
                    d.word = word;
                    d.dir  = dir;
                    d.si   = si_in;
                    d.di   = di_in;
                    d.cx   = cx_in;
                    d.ds   = ds_in;
                    d.es   = es_in;
                    d.acc  = acc_in;
                    d.bidx = '0;
                    if ((rep_mode_e'(rep) != RP_NONE) && (cx_in == '0))
                        d.st = ST_DONE;
                    else if (op_reads_src(str_op_e'(op)))
                        d.st = ST_SRC;
                    else
                        d.st = ST_DST;
                end
            end
            ST_SRC: begin
                if (mem_rdy) begin
                    d.sbuf[int'(q.bidx) * BYTE_W +: BYTE_W] = mem_rdata;
                    if (q.bidx == last_idx) begin
                        d.bidx = '0;
                        d.st   = op_uses_dst(q.op) ? ST_DST : ST_EVAL;
                    end else begin
                        d.bidx = q.bidx + IDX_W'(1);
                    end
                end
            end
            ST_DST: begin
                if (mem_rdy) begin
                    if (!op_writes_dst(q.op))
                        d.dbuf[int'(q.bidx) * BYTE_W +: BYTE_W] = mem_rdata;
                    if (q.bidx == last_idx) begin
                        d.bidx = '0;
                        d.st   = ST_EVAL;
                    end else begin
                        d.bidx = q.bidx + IDX_W'(1);
                    end
                end
            end
            ST_EVAL: begin
                d.zf = zf_new;
                if (q.op == OP_LOAD)
                    d.acc = (q.sbuf & mask) | (q.acc & ~mask);
                if (op_reads_src(q.op))
                    d.si = si_next;
                if (op_uses_dst(q.op))
                    d.di = di_next;
                if (q.rep == RP_NONE) begin
                    d.st = ST_DONE;
                end else begin
                    d.cx = cx_dec;
                    if (keep_going)
                        d.st = op_reads_src(q.op) ? ST_SRC : ST_DST;
                    else
                        d.st = ST_DONE;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.op   <= OP_COPY;
            q.rep  <= RP_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign done    = (q.st == ST_DONE);
    assign zf      = q.zf;
    assign si_out  = q.si;
    assign di_out  = q.di;
    assign cx_out  = q.cx;
    assign acc_out = q.acc;

endmodule

// File: rtl/strx_checker.sv
module strx_checker #(
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        rep,
    input logic [OFF_W-1:0]  cx_in,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_rdy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic [OFF_W-1:0]  cx_out
);
    logic [1:0]       rep_seen;
    logic [OFF_W-1:0] cx_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_seen <= 2'd0;
            cx_seen  <= '0;
        end else if (start && !busy) begin
            rep_seen <= rep;
            cx_seen  <= cx_in;
        end
    end

    // R10: a pending request keeps its address, direction and data
    assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11: no memory traffic while idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R11: end pulse lasts one cycle
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: zero count with a repeat ends at once without memory traffic
    assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (rep != 2'd0) && (cx_in == '0)) |=> (done && !mem_req));

    // R6: without repeat the count is returned unchanged
    assert_single_keeps_cx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (rep_seen == 2'd0)) |-> (cx_out == cx_seen));

    // R7: counted repeat always drains the count
    assert_count_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (rep_seen == 2'd1)) |-> (cx_out == '0));

endmodule

bind strx_engine strx_checker #(.OFF_W(OFF_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tb_strx_engine.sv
module tb_strx_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [1:0]  rep = 2'd0;
    logic        word = 1'b0;
    logic        dir = 1'b0;
    logic [15:0] si_in = '0, di_in = '0, cx_in = '0, ds_in = '0, es_in = '0, acc_in = '0;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic        busy, done, zf;
    logic [15:0] si_out, di_out, cx_out, acc_out;

    strx_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rep(rep), .word(word), .dir(dir),
        .si_in(si_in), .di_in(di_in), .cx_in(cx_in), .ds_in(ds_in), .es_in(es_in), .acc_in(acc_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .busy(busy), .done(done), .zf(zf),
        .si_out(si_out), .di_out(di_out), .cx_out(cx_out), .acc_out(acc_out)
    );

    always #5 clk = ~clk;

    int    errs = 0;
    int    checks = 0;
    int    cycles_total = 0;
    string cur_req = "R11";
    bit    stall_en = 1'b0;
    int    stall_ctr = 0;

    logic [7:0] mem [int];
    logic [7:0] mdl [int];

    int         exp_addr [$];
    bit         exp_we [$];
    logic [7:0] exp_wd [$];

    logic [15:0] e_si, e_di, e_cx, e_acc;
    logic        e_zf = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] dflt(input int a);
        return 8'((a * 7 + (a >>> 8) + 3) & 255);
    endfunction

    function automatic logic [7:0] rd_mem(input int a);
        return mem.exists(a) ? mem[a] : dflt(a);
    endfunction

    function automatic logic [7:0] rd_mdl(input int a);
        return mdl.exists(a) ? mdl[a] : dflt(a);
    endfunction

    function automatic int phys(input logic [15:0] s, input logic [15:0] o, input int b);
        logic [15:0] ob;
        ob = o + 16'(b);
        return ((int'(s) << 4) + int'(ob)) & 32'hFFFFF;
    endfunction

    // Behavioural model: predicts every byte transfer and the final state.
    task automatic model_run(input int o, input int r, input bit w, input bit dr,
                             input logic [15:0] si, input logic [15:0] di, input logic [15:0] cx,
                             input logic [15:0] ds, input logic [15:0] es, input logic [15:0] acc);
        int  n;
        bit  rd_src, use_dst, wr_dst;
        n = w ? 2 : 1;
        rd_src  = (o == 0) || (o == 1) || (o == 3);
        use_dst = (o != 3);
        wr_dst  = (o == 0) || (o == 4);
        exp_addr.delete(); exp_we.delete(); exp_wd.delete();
        mdl = mem;
        if (!(r != 0 && cx == 0)) begin
            forever begin
                logic [15:0] sv, dv, av;
                bit eq, go;
                sv = '0; dv = '0;
                if (rd_src)
                    for (int b = 0; b < n; b++) begin
                        int a;
                        a = phys(ds, si, b);
                        exp_addr.push_back(a); exp_we.push_back(1'b0); exp_wd.push_back(8'h00);
                        sv[8*b +: 8] = rd_mdl(a);
                    end
                if (use_dst)
                    for (int b = 0; b < n; b++) begin
                        int a;
                        a = phys(es, di, b);
                        if (wr_dst) begin
                            logic [7:0] v;
                            v = (o == 0) ? sv[8*b +: 8] : acc[8*b +: 8];
                            exp_addr.push_back(a); exp_we.push_back(1'b1); exp_wd.push_back(v);
                            mdl[a] = v;
                        end else begin
                            exp_addr.push_back(a); exp_we.push_back(1'b0); exp_wd.push_back(8'h00);
                            dv[8*b +: 8] = rd_mdl(a);
                        end
                    end
                av = (o == 1) ? sv : acc;
                eq = w ? (av == dv) : (av[7:0] == dv[7:0]);
                if (o == 1 || o == 2) e_zf = eq;
                if (o == 3) acc = w ? sv : {acc[15:8], sv[7:0]};
                if (rd_src)  si = dr ? si - 16'(n) : si + 16'(n);
                if (use_dst) di = dr ? di - 16'(n) : di + 16'(n);
                if (r == 0) break;
                cx = cx - 16'd1;
                go = (cx != 0);
                if ((o == 1 || o == 2) && r == 2 && !e_zf) go = 0;
                if ((o == 1 || o == 2) && r == 3 &&  e_zf) go = 0;
                if (!go) break;
            end
        end
        e_si = si; e_di = di; e_cx = cx; e_acc = acc;
    endtask

    // Memory responder: decides readiness away from the active edge.
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            bit rdy;
            stall_ctr++;
            rdy = !stall_en || (stall_ctr % 3 == 2);
            if (rdy) begin
                if (exp_addr.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected transfer addr", mem_addr, 0);
                end else begin
                    bit ok;
                    ok = (int'(mem_addr) == exp_addr[0]) && (mem_we == exp_we[0]) &&
                         (!exp_we[0] || mem_wdata == exp_wd[0]);
                    chk(ok, cur_req, $sformatf("transfer we=%0b wd=%0h", mem_we, mem_wdata),
                        mem_addr, exp_addr[0]);
                    exp_addr.pop_front(); exp_we.pop_front(); exp_wd.pop_front();
                end
                if (mem_we) mem[int'(mem_addr)] = mem_wdata;
                mem_rdata = rd_mem(int'(mem_addr));
            end
            mem_rdy = rdy;
        end else begin
            mem_rdy = 1'b0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles_total++;
        if (cycles_total > 100000) begin
            chk(1'b0, "R11", "watchdog expired", cycles_total, 100000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic run(input int o, input int r, input bit w, input bit dr,
                       input logic [15:0] si, input logic [15:0] di, input logic [15:0] cx,
                       input logic [15:0] ds, input logic [15:0] es, input logic [15:0] acc,
                       input bit stl, input bit poke, input string req);
        int cyc;
        cur_req  = req;
        stall_en = stl;
        model_run(o, r, w, dr, si, di, cx, ds, es, acc);
        @(negedge clk);
        op = 3'(o); rep = 2'(r); word = w; dir = dr;
        si_in = si; di_in = di; cx_in = cx; ds_in = ds; es_in = es; acc_in = acc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 2000) begin
            if (poke && cyc == 3) begin
                start = 1'b1; op = 3'd4; rep = 2'd1; cx_in = 16'd9; acc_in = 16'hDEAD;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk(done == 1'b1, req, "done seen", done, 1);
        if (r != 0 && cx == 0)
            chk(cyc == 1, "R9", "cycles to done", cyc, 1);
        chk(si_out == e_si, req, "si_out", si_out, e_si);
        chk(di_out == e_di, req, "di_out", di_out, e_di);
        chk(cx_out == e_cx, req, "cx_out", cx_out, e_cx);
        chk(acc_out == e_acc, req, "acc_out", acc_out, e_acc);
        chk(zf == e_zf, req, "zf", zf, e_zf);
        chk(exp_addr.size() == 0, req, "missing transfers", exp_addr.size(), 0);
        @(negedge clk);
        chk(!done && !busy, "R11", "done pulse ends", {done, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !zf, "R11", "reset state",
            {busy, done, mem_req, zf}, 0);

        // R2 R6: single byte copy, count untouched
        run(0, 0, 0, 0, 16'h0010, 16'h0020, 16'd5, 16'h1000, 16'h2000, 16'h0000, 0, 0, "R2 R6");
        // R5 R7: counted word copy, shrinking offsets
        run(0, 1, 1, 1, 16'h0040, 16'h0080, 16'd3, 16'h1000, 16'h2000, 16'h0000, 0, 0, "R5 R7");
        // R3: counted word store
        run(4, 1, 1, 0, 16'h0000, 16'h0100, 16'd4, 16'h1000, 16'h2000, 16'hBEEF, 0, 0, "R3 store");
        // R3: byte load keeps upper accumulator byte
        run(3, 1, 0, 0, 16'h0300, 16'h0000, 16'd2, 16'h1000, 16'h2000, 16'h1234, 0, 0, "R3 load");

        // R4 R8: compare while equal stops on third word
        mem[32'h10100] = 8'h11; mem[32'h10101] = 8'h22;
        mem[32'h10102] = 8'h33; mem[32'h10103] = 8'h44;
        mem[32'h10104] = 8'h55; mem[32'h10105] = 8'h66;
        mem[32'h20200] = 8'h11; mem[32'h20201] = 8'h22;
        mem[32'h20202] = 8'h33; mem[32'h20203] = 8'h44;
        mem[32'h20204] = 8'h55; mem[32'h20205] = 8'h67;
        run(1, 2, 1, 0, 16'h0100, 16'h0200, 16'd5, 16'h1000, 16'h2000, 16'h0000, 0, 0, "R4 R8 cmp");

        // R4 R8: scan while not equal finds the value on the fourth byte
        mem[32'h30050] = 8'h01; mem[32'h30051] = 8'h02;
        mem[32'h30052] = 8'h03; mem[32'h30053] = 8'h5A;
        run(2, 3, 0, 0, 16'h0000, 16'h0050, 16'd10, 16'h1000, 16'h3000, 16'h775A, 0, 0, "R4 R8 scan");

        // R9: zero count with a repeat
        run(0, 1, 1, 0, 16'h0123, 16'h0456, 16'd0, 16'h1000, 16'h2000, 16'hCAFE, 0, 0, "R9");

        // R1: segment and offset wrap inside one word load
        run(3, 0, 1, 0, 16'hFFFF, 16'h0000, 16'd7, 16'hFFFF, 16'h2000, 16'h0000, 0, 0, "R1");

        // R10 R11: stalling memory and a start raised while busy
        run(0, 1, 1, 0, 16'h0500, 16'h0600, 16'd3, 16'h4000, 16'h5000, 16'h0000, 1, 1, "R10 R11");

        // R8: conditional repeat on a store runs on the count only
        run(4, 2, 0, 1, 16'h0000, 16'h0010, 16'd3, 16'h1000, 16'h6000, 16'h00A5, 0, 0, "R8 store");

        // R4 R6: single equal byte compare sets zf
        mem[32'h17000] = 8'h9C; mem[32'h27000] = 8'h9C;
        run(1, 0, 0, 0, 16'h7000, 16'h7000, 16'd2, 16'h1000, 16'h2000, 16'h0000, 0, 0, "R4 R6");

        // R5: stalled word scan with shrinking offset wraps through zero
        run(2, 1, 1, 1, 16'h0000, 16'h0002, 16'd3, 16'h1000, 16'h2000, 16'h0000, 1, 0, "R5 scan");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule